// File: doc/BRIEF.md
# Low-Power Clock Gate Controller

This block sits between the clock sources and the clock consumers of a small 16-bit microcontroller. It takes the fast on-chip clock (the DCO root) and a slow crystal clock, and produces three gated clocks: the CPU clock, the fast peripheral clock and the slow auxiliary clock. It also produces a run request for the DCO oscillator. Four power-saving bits from the CPU status word decide which clocks stop. Each bit has its own effect: the CPU clock halts, the crystal-derived clock halts, the DCO is asked to power down, or the fast peripheral clock halts.

Interrupts override the power-saving bits. A synchronized external wakeup request forces every clock on, so the sleeping CPU can take the interrupt. From the acknowledge of an interrupt until its matching return, every clock stays forced on. Nested entries are counted. After the last return, gating again follows the status bits as they are presented at that moment. A handler that cleared the bits in its saved copy therefore leaves the part awake, and one that left them unchanged sends it back to sleep. Two build parameters can remove the gating of the peripheral clock and of the auxiliary clock.

Each gate enable is captured on the falling edge of its source clock. As a result, every gated clock shows only whole pulses.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While reset is low and on the first cycles after it, with `lp_bits` = 0, all three gated clocks toggle with their sources, `dco_en` is 1 and `wake_irq` is all zeros.
- R2: With `lp_bits[0]` (CPU off) set and no force active, `mclk` stays low. Clearing it lets `mclk` follow `clk_dco` again. `smclk` is not affected by this bit.
- R3: With `lp_bits[1]` (crystal clock off) set, no force active and `LFOSC_GATE_EN`=1, `aclk` stays low. Otherwise it follows `clk_lf`.
- R4: With `lp_bits[2]` (DCO off) set and no force active, `dco_en` is 0. Otherwise it is 1.
- R5: With `lp_bits[3]` (peripheral clock off) set, no force active and `SMCLK_GATE_EN`=1, `smclk` stays low. Otherwise it follows `clk_dco`.
- R6: When `SMCLK_GATE_EN`=0 or `LFOSC_GATE_EN`=0, setting the matching bit has no effect: that clock keeps running.
- R7: After a one-cycle `irq_ack` pulse, all three clocks run and `dco_en` is 1, whatever `lp_bits` holds, until the matching `irq_ret`.
- R8: Entries nest. Each `irq_ack` raises a service depth and each `irq_ret` lowers it. The depth saturates at 2^`SVC_DEPTH_W`-1 and never goes below zero. Clocks stay forced while the depth is nonzero.
- R9: When the depth returns to zero, gating follows `lp_bits` as presented then. Bits that were cleared keep the clocks running, and bits still set stop them again.
- R10: `wake_irq[i]` becomes 1 on the second rising `clk_dco` edge after `wake_in[i]` goes high. It is held at 0 while reset is low.
- R11: While any `wake_irq` bit is 1, all clocks are forced on. With CPU off set, the first `mclk` pulse starts at the `clk_dco` rising edge right after `wake_irq` rises.
- R12: Every rising edge of `mclk` and `smclk` coincides with a rising edge of `clk_dco`, and every falling edge of either occurs while `clk_dco` is low. No shortened pulses appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dco | input | 1 | Free-running DCO root clock, source of mclk and smclk |
| clk_lf | input | 1 | Free-running low-frequency crystal clock, source of aclk |
| rst_n | input | 1 | Synchronous active-low power-up clear |
| lp_bits | input | 4 | Status power-saving bits: [0] CPU off, [1] crystal clock off, [2] DCO off, [3] peripheral clock off |
| irq_ack | input | 1 | One-cycle pulse: an interrupt entered service |
| irq_ret | input | 1 | One-cycle pulse: a return from interrupt completed |
| wake_in | input | N_WAKE | Asynchronous external wakeup lines |
| mclk | output | 1 | Gated CPU clock |
| smclk | output | 1 | Gated fast peripheral clock |
| aclk | output | 1 | Gated auxiliary clock from the crystal |
| dco_en | output | 1 | Run request to the DCO oscillator |
| wake_irq | output | N_WAKE | Synchronized wakeup interrupt requests |

## Verification
A service depth that is off by one appears at the ports as a clock that stops one return too early or stays on one return too long. This shows up within a cycle of the offending `irq_ret`, so the bench probes the depth around nested and saturated entry counts. A gate enable captured on the wrong edge first appears as a falling clock edge while `clk_dco` is high. A synchronizer with the wrong length moves the `wake_irq` rise, and with it the first `mclk` pulse, by a whole cycle. Both are sampled on the exact edge.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the low-power clock gate controller.
// Assumes the four power-saving bits arrive as one packed nibble in the
// order defined by lp_ctrl_t (first member is the most significant bit).
package lpm_pkg;

    // View of the power-saving nibble, bit 3 down to bit 0.
    typedef struct packed {
        logic smclk_off;   // bit 3: stop fast peripheral clock
        logic dco_off;     // bit 2: ask DCO oscillator to stop
        logic lf_off;      // bit 1: stop crystal-derived clock
        logic cpu_off;     // bit 0: stop CPU clock
    } lp_ctrl_t;

    localparam int LP_WIDTH = $bits(lp_ctrl_t);

endpackage

// File: rtl/lpm_wake_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer per wakeup line, clocked by the ungated CPU clock
// root so that a request still propagates while the CPU clock is stopped.
// Assumes wake lines are level requests held until serviced.
module lpm_wake_sync #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] wake_async,
    output logic [N_LINES-1:0] wake_sync
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_lane
        logic [1:0] stage;

        // Shift the raw line through two flops; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage <= 2'b00;
            end else begin
                stage <= {stage[0], wake_async[i]};
            end
        end

        assign wake_sync[i] = stage[1];

        AST_WAKE_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wake_sync[i]) |-> $past(wake_async[i], 2)); // R10
    end

endmodule

// File: rtl/lpm_service_track.sv
`timescale 1ns/1ps
// Counts nested interrupt service entries. Acknowledge raises the depth,
// return lowers it; the count saturates at both ends. Assumes acknowledge
// and return are single-cycle pulses in the clk domain.
module lpm_service_track #(
    parameter int DEPTH_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic ret,
    output logic active
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    logic [DEPTH_W-1:0] depth;

    // Update the nesting depth; simultaneous ack and return cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (ack && !ret && depth != DEPTH_MAX) begin
            depth <= depth + DEPTH_ONE;
        end else if (ret && !ack && depth != '0) begin
            depth <= depth - DEPTH_ONE;
        end
    end

    assign active = (depth != '0);

    AST_DEPTH_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !ret) |=> $stable(depth)); // R8
    AST_LAST_RET_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == DEPTH_ONE && ret && !ack) |=> !active); // R9

endmodule

// File: rtl/lpm_clk_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate. The run request is optionally brought into the
// source clock domain through SYNC_STAGES flops, then captured on the
// falling edge so the enable only moves while the source is low. With
// GATE_EN = 0 the source passes straight through.
module lpm_clk_gate #(
    parameter bit GATE_EN     = 1'b1,
    parameter int SYNC_STAGES = 0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic run_req,
    output logic gclk
);

    logic run_s;

    if (SYNC_STAGES > 0) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;

        // Resynchronize the run request into the source clock domain.
        always_ff @(posedge clk_src) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain[0] <= run_req;
                for (int k = 1; k < SYNC_STAGES; k++) begin
                    chain[k] <= chain[k-1];
                end
            end
        end

        assign run_s = chain[SYNC_STAGES-1];
    end else begin : g_direct
        assign run_s = run_req;
    end

    if (GATE_EN) begin : g_gate
        logic en_q;

        // Capture the enable while the source clock is low.
        always_ff @(negedge clk_src) begin
            if (!rst_n) begin
                en_q <= 1'b1;
            end else begin
                en_q <= run_s;
            end
        end

        assign gclk = clk_src & en_q;
    end else begin : g_pass
        assign gclk = clk_src;
    end

endmodule

// File: rtl/lpm_clock_ctrl.sv
`timescale 1ns/1ps
// Low-power clock gate controller. Combines the power-saving status bits
// with a force term (interrupt service or pending wakeup) into per-clock
// run requests, and gates the CPU, peripheral and auxiliary clocks.
// Assumes irq_ack, irq_ret and lp_bits are driven in the clk_dco domain
// and that reset is held for several clk_lf periods.
module lpm_clock_ctrl #(
    parameter int N_WAKE         = 2,
    parameter int SVC_DEPTH_W    = 3,
    parameter bit SMCLK_GATE_EN  = 1'b1,
    parameter bit LFOSC_GATE_EN  = 1'b1,
    parameter int LF_SYNC_STAGES = 2
) (
    input  logic                       clk_dco,
    input  logic                       clk_lf,
    input  logic                       rst_n,
    input  logic [lpm_pkg::LP_WIDTH-1:0] lp_bits,
    input  logic                       irq_ack,
    input  logic                       irq_ret,
    input  logic [N_WAKE-1:0]          wake_in,
    output logic                       mclk,
    output logic                       smclk,
    output logic                       aclk,
    output logic                       dco_en,
    output logic [N_WAKE-1:0]          wake_irq
);

    import lpm_pkg::*;

    lp_ctrl_t lp;
    logic     svc_active;
    logic     wake_any;
    logic     force_on;
    logic     mclk_run;
    logic     smclk_run;
    logic     aclk_run;

    assign lp = lp_ctrl_t'(lp_bits);

    lpm_wake_sync #(
        .N_LINES (N_WAKE)
    ) u_wake (
        .clk        (clk_dco),
        .rst_n      (rst_n),
        .wake_async (wake_in),
        .wake_sync  (wake_irq)
    );

    lpm_service_track #(
        .DEPTH_W (SVC_DEPTH_W)
    ) u_svc (
        .clk    (clk_dco),
        .rst_n  (rst_n),
        .ack    (irq_ack),
        .ret    (irq_ret),
        .active (svc_active)
    );

    // Derive the force term and per-clock run requests.
    always_comb begin
        wake_any  = |wake_irq;
        force_on  = svc_active | wake_any;
        mclk_run  = force_on | !lp.cpu_off;
        smclk_run = force_on | !lp.smclk_off;
        aclk_run  = force_on | !lp.lf_off;
        dco_en    = force_on | !lp.dco_off;
    end

    lpm_clk_gate #(
        .GATE_EN     (1'b1),
        .SYNC_STAGES (0)
    ) u_gate_m (
        .clk_src (clk_dco),
        .rst_n   (rst_n),
        .run_req (mclk_run),
        .gclk    (mclk)
    );

    lpm_clk_gate #(
        .GATE_EN     (SMCLK_GATE_EN),
        .SYNC_STAGES (0)
    ) u_gate_s (
        .clk_src (clk_dco),
        .rst_n   (rst_n),
        .run_req (smclk_run),
        .gclk    (smclk)
    );

    lpm_clk_gate #(
        .GATE_EN     (LFOSC_GATE_EN),
        .SYNC_STAGES (LF_SYNC_STAGES)
    ) u_gate_a (
        .clk_src (clk_lf),
        .rst_n   (rst_n),
        .run_req (aclk_run),
        .gclk    (aclk)
    );

    // Sampled just before each falling edge, the gated clocks show the
    // high phase chosen by the previous cycle's request.
    AST_FORCE_RUNS_MCLK: assert property (@(negedge clk_dco) disable iff (!rst_n)
        $past(rst_n && force_on) |-> mclk); // R7
    AST_CPUOFF_HALTS_MCLK: assert property (@(negedge clk_dco) disable iff (!rst_n)
        $past(rst_n && !force_on && lp.cpu_off) |-> !mclk); // R2
    AST_SMCLK_OFF_HALTS: assert property (@(negedge clk_dco) disable iff (!rst_n)
        $past(rst_n && !force_on && lp.smclk_off && SMCLK_GATE_EN) |-> !smclk); // R5
    AST_FORCE_RUNS_SMCLK: assert property (@(negedge clk_dco) disable iff (!rst_n)
        $past(rst_n && wake_any) |-> smclk); // R11

endmodule

// File: tb/lpm_clock_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_clock_ctrl_tb_top;

    localparam int WIN  = 16;   // clk_dco cycles per measurement window
    localparam int LWIN = 8;    // clk_lf cycles per measurement window

    // {lp_bits, expected run mask}; mask bit i set = feature of bit i active
    // (0 mclk runs, 1 aclk runs, 2 dco_en high, 3 smclk runs).
    localparam logic [7:0] VEC [8] = '{
        {4'b0000, 4'b1111},
        {4'b0001, 4'b1110},
        {4'b0010, 4'b1101},
        {4'b0100, 4'b1011},
        {4'b1000, 4'b0111},
        {4'b1111, 4'b0000},
        {4'b1010, 4'b0101},
        {4'b0101, 4'b1010}
    };

    logic       clk_dco = 1'b0;
    logic       clk_lf  = 1'b0;
    logic       rst_n   = 1'b0;
    logic [3:0] lp_bits = 4'b0000;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic [1:0] wake_in = 2'b00;
    logic       mclk, smclk, aclk, dco_en;
    logic [1:0] wake_irq;
    logic       mclk2, smclk2, aclk2, dco_en2;
    logic [1:0] wake_irq2;

    int n_chk  = 0;
    int n_fail = 0;
    int m_cnt = 0, s_cnt = 0, a_cnt = 0, s2_cnt = 0, a2_cnt = 0;
    int glitches = 0;

    always #4 clk_dco = ~clk_dco;           // 125 MHz
    initial begin
        #3;
        forever #32 clk_lf = ~clk_lf;
    end

    lpm_clock_ctrl dut_i (
        .clk_dco (clk_dco), .clk_lf (clk_lf), .rst_n (rst_n),
        .lp_bits (lp_bits), .irq_ack (irq_ack), .irq_ret (irq_ret),
        .wake_in (wake_in), .mclk (mclk), .smclk (smclk), .aclk (aclk),
        .dco_en (dco_en), .wake_irq (wake_irq)
    );

    lpm_clock_ctrl #(
        .SMCLK_GATE_EN (1'b0),
        .LFOSC_GATE_EN (1'b0)
    ) dut_nogate_i (
        .clk_dco (clk_dco), .clk_lf (clk_lf), .rst_n (rst_n),
        .lp_bits (lp_bits), .irq_ack (irq_ack), .irq_ret (irq_ret),
        .wake_in (wake_in), .mclk (mclk2), .smclk (smclk2), .aclk (aclk2),
        .dco_en (dco_en2), .wake_irq (wake_irq2)
    );

    always @(posedge mclk)   m_cnt  <= m_cnt + 1;
    always @(posedge smclk)  s_cnt  <= s_cnt + 1;
    always @(posedge aclk)   a_cnt  <= a_cnt + 1;
    always @(posedge smclk2) s2_cnt <= s2_cnt + 1;
    always @(posedge aclk2)  a2_cnt <= a2_cnt + 1;

    // R12 monitor: gated edges must line up with the source phases.
    always @(posedge mclk)  if (rst_n && clk_dco !== 1'b1) glitches <= glitches + 1;
    always @(negedge mclk)  if (rst_n && clk_dco !== 1'b0) glitches <= glitches + 1;
    always @(posedge smclk) if (rst_n && clk_dco !== 1'b1) glitches <= glitches + 1;
    always @(negedge smclk) if (rst_n && clk_dco !== 1'b0) glitches <= glitches + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_bits(input logic [3:0] v);
        @(posedge clk_dco); #2;
        lp_bits = v;
    endtask

    task automatic pulse_ack();
        @(posedge clk_dco); #2; irq_ack = 1'b1;
        @(posedge clk_dco); #2; irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        @(posedge clk_dco); #2; irq_ret = 1'b1;
        @(posedge clk_dco); #2; irq_ret = 1'b0;
    endtask

    // Count gated edges over settled windows of each source clock.
    task automatic measure(output int dm, output int ds, output int da,
                           output int ds2, output int da2, output int den);
        int m0, s0, a0, s20, a20;
        repeat (4) @(negedge clk_dco);
        m0 = m_cnt; s0 = s_cnt; s20 = s2_cnt;
        repeat (WIN) @(negedge clk_dco);
        dm = m_cnt - m0; ds = s_cnt - s0; ds2 = s2_cnt - s20;
        den = int'(dco_en);
        repeat (5) @(negedge clk_lf);
        a0 = a_cnt; a20 = a2_cnt;
        repeat (LWIN) @(negedge clk_lf);
        da = a_cnt - a0; da2 = a2_cnt - a20;
    endtask

    initial begin
        #(150000 * 8);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dm, ds, da, ds2, da2, den;

        // R1 / R10: reset state, wake lines held high during reset.
        wake_in = 2'b11;
        repeat (40) @(negedge clk_dco);
        check(wake_irq == 2'b00, "R10 wake_irq cleared in reset", int'(wake_irq), 0);
        check(dco_en == 1'b1, "R1 dco_en in reset", int'(dco_en), 1);
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R1 mclk runs in reset", dm, WIN);
        check(ds == WIN, "R1 smclk runs in reset", ds, WIN);
        check(da == LWIN, "R1 aclk runs in reset", da, LWIN);
        @(posedge clk_dco); #2;
        wake_in = 2'b00;
        @(posedge clk_dco); #2;
        rst_n = 1'b1;
        @(negedge clk_dco);
        check(wake_irq == 2'b00, "R1 wake_irq after reset", int'(wake_irq), 0);

        // Table walk: R2 R3 R4 R5 for the gated part, R6 for the ungated one.
        for (int i = 0; i < 8; i++) begin
            set_bits(VEC[i][7:4]);
            measure(dm, ds, da, ds2, da2, den);
            check(dm == (VEC[i][0] ? WIN : 0), "R2 mclk", dm, VEC[i][0] ? WIN : 0);
            check(da == (VEC[i][1] ? LWIN : 0), "R3 aclk", da, VEC[i][1] ? LWIN : 0);
            check(den == int'(VEC[i][2]), "R4 dco_en", den, int'(VEC[i][2]));
            check(ds == (VEC[i][3] ? WIN : 0), "R5 smclk", ds, VEC[i][3] ? WIN : 0);
            check(ds2 == WIN, "R6 smclk ungated", ds2, WIN);
            check(da2 == LWIN, "R6 aclk ungated", da2, LWIN);
        end

        // R10 / R11: wakeup timing while everything is off.
        set_bits(4'b1111);
        repeat (4) @(negedge clk_dco);
        @(posedge clk_dco); #2; wake_in[1] = 1'b1;
        @(posedge clk_dco); #2;
        check(wake_irq[1] == 1'b0, "R10 one edge after wake", int'(wake_irq[1]), 0);
        @(posedge clk_dco); #2;
        check(wake_irq[1] == 1'b1, "R10 two edges after wake", int'(wake_irq[1]), 1);
        check(mclk == 1'b0, "R11 mclk still low on sync edge", int'(mclk), 0);
        @(posedge clk_dco); #2;
        check(mclk == 1'b1, "R11 mclk pulse next edge", int'(mclk), 1);
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R11 mclk forced by wake", dm, WIN);
        check(ds == WIN, "R11 smclk forced by wake", ds, WIN);
        check(den == 1, "R11 dco_en forced by wake", den, 1);

        // R7: service keeps clocks on after the wake line drops.
        pulse_ack();
        @(posedge clk_dco); #2; wake_in[1] = 1'b0;
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R7 mclk in service", dm, WIN);
        check(ds == WIN, "R7 smclk in service", ds, WIN);
        check(da == LWIN, "R7 aclk in service", da, LWIN);
        check(den == 1, "R7 dco_en in service", den, 1);

        // R9: return with bits unchanged goes back to sleep.
        pulse_ret();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == 0, "R9 mclk stops after return", dm, 0);
        check(den == 0, "R9 dco_en low after return", den, 0);

        // R8: nesting, two entries and one return stay forced.
        pulse_ack();
        pulse_ack();
        pulse_ret();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R8 still forced at depth one", dm, WIN);
        pulse_ret();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == 0, "R8 released at depth zero", dm, 0);

        // R8: saturation, nine entries count as seven.
        for (int k = 0; k < 9; k++) pulse_ack();
        for (int k = 0; k < 6; k++) pulse_ret();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R8 forced one return before saturated count", dm, WIN);
        pulse_ret();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == 0, "R8 saturated depth drained", dm, 0);
        pulse_ret();
        pulse_ack();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R8 no underflow below zero", dm, WIN);

        // R9: handler clears the bits before its return.
        set_bits(4'b0000);
        pulse_ret();
        measure(dm, ds, da, ds2, da2, den);
        check(dm == WIN, "R9 mclk stays on after edited return", dm, WIN);
        check(ds == WIN, "R9 smclk stays on after edited return", ds, WIN);
        check(da == LWIN, "R9 aclk stays on after edited return", da, LWIN);

        // R12: no partial pulses seen over the whole run.
        check(glitches == 0, "R12 partial pulses", glitches, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule